// File: doc/BRIEF.md
# Lookahead-Driven Head Cell Prefetcher

This block sits between an external arbiter and a slow backing memory that holds the cells of several per-flow queues. Each arbiter request names a queue. The request goes into a delay line of fixed length. While it travels down the line, a per-queue signed deficit counter works out whether the cells already ordered will cover it. When they will not, a fetch of one block of cells for that queue is queued.

A single scheduler drains the queued fetches in the order they were raised. It issues at most one fetch per block period, and only when the shared head store can take a whole block. Space is set aside when the fetch leaves, not when its data lands. Fill beats return in issue order and are appended to the queue's linked list inside a shared cell store. A free-cell bitmap hands out the slots.

When a request reaches the end of the delay line, the head cell of its queue is sent out. If that queue holds no cell at that moment, the request is reported as dropped. A drop happens either because the data is still on its way, or because the fetch is stalled waiting for room.

Top module: `hcache_prefetch`

## Requirements
- R1: Every accepted request produces exactly one outcome, either a cell or a drop, carrying the request's queue ID. The outcome is visible exactly LA clock cycles after the edge that sampled the request.
- R2: For each queue, delivered cells appear in the same order as their fill beats arrived, and a cell not consumed stays in the store for that queue's later requests.
- R3: Starting from reset, the 1st, (BLK+1)th, (2·BLK+1)th and later requests of that form for a queue each raise exactly one fetch command for that queue; all other requests raise none.
- R4: Fetch commands leave in the order in which their queues became critical.
- R5: Two fetch commands are separated by at least BLK cycles.
- R6: A fetch is issued only while at least BLK cells of the store are neither occupied nor already set aside. With NCELL equal to BLK, a second fetch waits until that room exists.
- R7: When the requested queue holds no cell at the end of the delay line, drop_vld pulses for one cycle with drop_qid equal to the queue, and no cell is sent.
- R8: With no queue critical, no fetch command is issued.
- R9: During reset, fetch_vld, cell_vld and drop_vld are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Arbiter request strobe |
| req_qid | input | QW | Queue ID of the request |
| fetch_vld | output | 1 | Fetch command to backing memory, one cycle |
| fetch_qid | output | QW | Queue to fetch BLK cells for |
| fill_vld | input | 1 | Fill beat from backing memory, BLK beats per fetch in issue order |
| fill_data | input | DW | Fill beat payload |
| cell_vld | output | 1 | Cell delivered for a request leaving the delay line |
| cell_qid | output | QW | Queue of the delivered cell |
| cell_data | output | DW | Delivered cell payload |
| drop_vld | output | 1 | Request dropped, one cycle |
| drop_qid | output | QW | Queue of the dropped request |

## Verification
If a deficit counter is corrupted, the fetch commands come out too many, too few or in the wrong order. This shows on fetch_vld and fetch_qid within a cycle or a few block periods of the triggering request. If a linked list or the free bitmap goes wrong, a cell arrives with the wrong payload or a spurious drop appears. That becomes visible only when the affected request leaves the delay line, LA cycles after it entered. Any loss of track of the set-aside space shows up either as a fetch issued while the store is full or as one that is never issued. The second case surfaces as a drop at the end of the delay line.

// File: rtl/hcp_pkg.sv
`timescale 1ns/1ps
package hcp_pkg;
  // Registered outcome of a request leaving the delay line
  typedef enum logic [1:0] {EV_NONE, EV_CELL, EV_DROP} hcp_ev_e;
endpackage

// File: rtl/hcp_delay.sv
`timescale 1ns/1ps
// Fixed-length request delay line; shifts every cycle.
module hcp_delay #(
  parameter int LA = 16,
  parameter int QW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [QW-1:0] in_qid,
  output logic          out_vld,
  output logic [QW-1:0] out_qid
);
  logic [LA-1:0] v_q, v_d;
  logic [QW-1:0] q_q [LA];
  logic [QW-1:0] q_d [LA];

  always_comb begin
    v_d[0] = in_vld;
    q_d[0] = in_qid;
    for (int i = 1; i < LA; i++) begin
      v_d[i] = v_q[i-1];
      q_d[i] = q_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < LA; i++) q_q[i] <= '0;
    end else begin
      v_q <= v_d;
      for (int i = 0; i < LA; i++) q_q[i] <= q_d[i];
    end
  end

  assign out_vld = v_q[LA-1];
  assign out_qid = q_q[LA-1];
endmodule

// File: rtl/hcp_deficit.sv
`timescale 1ns/1ps
// Per-queue deficits, fetch command FIFO and paced issue.
module hcp_deficit #(
  parameter int NQ  = 4,
  parameter int BLK = 4,
  parameter int FFD = 8,
  parameter int QW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [QW-1:0] req_qid,
  input  logic          space_ok,
  output logic          fetch_vld,
  output logic [QW-1:0] fetch_qid
);
  localparam int DFW = $clog2(BLK) + 2;
  localparam int FPW = $clog2(FFD);
  localparam int GW  = $clog2(BLK);

  logic signed [DFW-1:0] def_q [NQ];
  logic signed [DFW-1:0] def_d [NQ];
  logic [QW-1:0]  ff_q [FFD];
  logic [FPW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [FPW:0]   cnt_q, cnt_d;
  logic [GW-1:0]  gap_q, gap_d;
  logic           fv_d;
  logic [QW-1:0]  fq_d;
  logic           crit, pop;

  always_comb begin
    crit = req_vld && (def_q[req_qid] == '0);
    for (int i = 0; i < NQ; i++) begin
      def_d[i] = def_q[i];
      if (req_vld && req_qid == QW'(i))
        def_d[i] = def_q[i] - DFW'(1) + (crit ? DFW'(BLK) : DFW'(0));
    end
    pop   = (cnt_q != '0) && (gap_q == '0) && space_ok;
    wr_d  = wr_q + FPW'(crit);
    rd_d  = rd_q + FPW'(pop);
    cnt_d = cnt_q + (FPW+1)'(crit) - (FPW+1)'(pop);
    gap_d = pop ? GW'(BLK-1) : ((gap_q != '0) ? gap_q - GW'(1) : gap_q);
    fv_d  = pop;
    fq_d  = ff_q[rd_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) def_q[i] <= '0;
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; gap_q <= '0;
      fetch_vld <= 1'b0; fetch_qid <= '0;
    end else begin
      for (int i = 0; i < NQ; i++) def_q[i] <= def_d[i];
      wr_q <= wr_d; rd_q <= rd_d; cnt_q <= cnt_d; gap_q <= gap_d;
      fetch_vld <= fv_d; fetch_qid <= fq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (crit) ff_q[wr_q] <= req_qid;
  end
endmodule

// File: rtl/hcp_store.sv
`timescale 1ns/1ps
// Shared head store: per-queue linked lists, free bitmap, space reservation.
module hcp_store
  import hcp_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int BLK   = 4,
  parameter int NCELL = 32,
  parameter int DW    = 8,
  parameter int OUTD  = 4,
  parameter int QW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [QW-1:0] fetch_qid,
  input  logic          fill_vld,
  input  logic [DW-1:0] fill_data,
  input  logic          pop_vld,
  input  logic [QW-1:0] pop_qid,
  output logic          space_ok,
  output logic          cell_vld,
  output logic [QW-1:0] cell_qid,
  output logic [DW-1:0] cell_data,
  output logic          drop_vld,
  output logic [QW-1:0] drop_qid
);
  localparam int CW  = $clog2(NCELL);
  localparam int AW  = CW + 1;
  localparam int OPW = $clog2(OUTD);
  localparam int BW  = $clog2(BLK);

  logic [DW-1:0]    mem [NCELL];
  logic [CW-1:0]    nxt [NCELL];
  logic [NCELL-1:0] used_q, used_d;
  logic [CW-1:0]    hd_q [NQ];
  logic [CW-1:0]    hd_d [NQ];
  logic [CW-1:0]    tl_q [NQ];
  logic [CW-1:0]    tl_d [NQ];
  logic [AW-1:0]    qc_q [NQ];
  logic [AW-1:0]    qc_d [NQ];
  logic [AW-1:0]    avail_q, avail_d;
  logic [QW-1:0]    of_q [OUTD];
  logic [OPW-1:0]   ofw_q, ofw_d, ofr_q, ofr_d;
  logic [BW-1:0]    beat_q, beat_d;
  hcp_ev_e          ev_q, ev_d;
  logic [QW-1:0]    oq_q;
  logic [DW-1:0]    od_q;

  logic [CW-1:0] alloc, phd;
  logic [QW-1:0] fq;
  logic          hit, last_beat, link, pop_i, push_i;

  always_comb begin
    alloc = '0;
    for (int i = NCELL-1; i >= 0; i--)
      if (!used_q[i]) alloc = CW'(i);
  end

  always_comb begin
    fq        = of_q[ofr_q];
    hit       = pop_vld && (qc_q[pop_qid] != '0);
    phd       = hd_q[pop_qid];
    last_beat = fill_vld && (beat_q == BW'(BLK-1));
    link      = fill_vld && !((qc_q[fq] == '0) ||
                (hit && pop_qid == fq && qc_q[fq] == AW'(1)));
    for (int i = 0; i < NQ; i++) begin
      pop_i  = hit && (pop_qid == QW'(i));
      push_i = fill_vld && (fq == QW'(i));
      hd_d[i] = hd_q[i];
      tl_d[i] = tl_q[i];
      if (pop_i) hd_d[i] = nxt[hd_q[i]];
      if (push_i) begin
        tl_d[i] = alloc;
        if (qc_q[i] == '0 || (pop_i && qc_q[i] == AW'(1))) hd_d[i] = alloc;
      end
      qc_d[i] = qc_q[i] + AW'(push_i) - AW'(pop_i);
    end
    used_d = used_q;
    if (hit) used_d[phd] = 1'b0;
    if (fill_vld) used_d[alloc] = 1'b1;
    avail_d = avail_q - (fetch_vld ? AW'(BLK) : AW'(0)) + AW'(hit);
    ofw_d   = ofw_q + OPW'(fetch_vld);
    ofr_d   = ofr_q + OPW'(last_beat);
    beat_d  = fill_vld ? (last_beat ? '0 : beat_q + BW'(1)) : beat_q;
    ev_d    = !pop_vld ? EV_NONE : (hit ? EV_CELL : EV_DROP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < NQ; i++) begin
        hd_q[i] <= '0; tl_q[i] <= '0; qc_q[i] <= '0;
      end
      avail_q <= AW'(NCELL);
      ofw_q <= '0; ofr_q <= '0; beat_q <= '0;
      ev_q <= EV_NONE; oq_q <= '0; od_q <= '0;
    end else begin
      used_q <= used_d;
      for (int i = 0; i < NQ; i++) begin
        hd_q[i] <= hd_d[i]; tl_q[i] <= tl_d[i]; qc_q[i] <= qc_d[i];
      end
      avail_q <= avail_d;
      ofw_q <= ofw_d; ofr_q <= ofr_d; beat_q <= beat_d;
      ev_q <= ev_d; oq_q <= pop_qid; od_q <= mem[phd];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_vld)  mem[alloc] <= fill_data;
    if (link)      nxt[tl_q[fq]] <= alloc;
    if (fetch_vld) of_q[ofw_q] <= fetch_qid;
  end

  assign space_ok  = avail_q >= AW'(BLK);
  assign cell_vld  = (ev_q == EV_CELL);
  assign drop_vld  = (ev_q == EV_DROP);
  assign cell_qid  = oq_q;
  assign drop_qid  = oq_q;
  assign cell_data = od_q;
endmodule

// File: rtl/hcache_prefetch.sv
`timescale 1ns/1ps
module hcache_prefetch #(
  parameter int NQ    = 4,
  parameter int BLK   = 4,
  parameter int LA    = 16,
  parameter int NCELL = 32,
  parameter int DW    = 8,
  parameter int FFD   = 8,
  parameter int OUTD  = 4,
  localparam int QW   = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [QW-1:0] req_qid,
  output logic          fetch_vld,
  output logic [QW-1:0] fetch_qid,
  input  logic          fill_vld,
  input  logic [DW-1:0] fill_data,
  output logic          cell_vld,
  output logic [QW-1:0] cell_qid,
  output logic [DW-1:0] cell_data,
  output logic          drop_vld,
  output logic [QW-1:0] drop_qid
);
  logic          dl_vld, space_ok;
  logic [QW-1:0] dl_qid;

  hcp_delay #(.LA(LA), .QW(QW)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_vld(req_vld), .in_qid(req_qid),
    .out_vld(dl_vld), .out_qid(dl_qid));

  hcp_deficit #(.NQ(NQ), .BLK(BLK), .FFD(FFD), .QW(QW)) u_def (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_qid(req_qid),
    .space_ok(space_ok), .fetch_vld(fetch_vld), .fetch_qid(fetch_qid));

  hcp_store #(.NQ(NQ), .BLK(BLK), .NCELL(NCELL), .DW(DW), .OUTD(OUTD), .QW(QW)) u_sto (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_qid(fetch_qid),
    .fill_vld(fill_vld), .fill_data(fill_data), .pop_vld(dl_vld), .pop_qid(dl_qid),
    .space_ok(space_ok), .cell_vld(cell_vld), .cell_qid(cell_qid),
    .cell_data(cell_data), .drop_vld(drop_vld), .drop_qid(drop_qid));
endmodule

// File: rtl/hcp_chk.sv
`timescale 1ns/1ps
module hcp_chk #(
  parameter int BLK   = 4,
  parameter int NCELL = 32,
  parameter int LA    = 16
) (
  input logic clk,
  input logic rst_n,
  input logic req_vld,
  input logic fetch_vld,
  input logic cell_vld,
  input logic drop_vld
);
  localparam int LW = $clog2(NCELL) + 3;
  localparam int IW = $clog2(LA + 2) + 2;

  logic [7:0]    since;
  logic [LW-1:0] live;
  logic [IW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 8'(BLK); live <= '0; inflight <= '0;
    end else begin
      since    <= fetch_vld ? 8'd1 : ((since < 8'(BLK)) ? since + 8'd1 : since);
      live     <= live + (fetch_vld ? LW'(BLK) : LW'(0)) - LW'(cell_vld);
      inflight <= inflight + IW'(req_vld) - IW'(cell_vld | drop_vld);
    end
  end

  a_r5_fetch_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> since >= 8'(BLK));
  a_r6_reserve_bound: assert property (@(posedge clk) disable iff (!rst_n)
    live <= LW'(NCELL));
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_vld && drop_vld));
  a_r1_outcome_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld || drop_vld) |-> inflight != '0);
  a_r1_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= IW'(LA + 1));
endmodule

bind hcache_prefetch hcp_chk #(.BLK(BLK), .NCELL(NCELL), .LA(LA)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .fetch_vld(fetch_vld),
  .cell_vld(cell_vld), .drop_vld(drop_vld));

// File: tb/sim_hcache_prefetch.sv
`timescale 1ns/1ps
// Behavioural backing memory: BLK beats per fetch, starting BLK cycles after issue.
// Beat payload = {queue, per-queue sequence number}.
module sim_mem #(parameter int QW = 2, parameter int DW = 8, parameter int BLK = 4) (
  input  logic          clk,
  input  logic          fetch_vld,
  input  logic [QW-1:0] fetch_qid,
  output logic          fill_vld,
  output logic [DW-1:0] fill_data
);
  int tick = 0;
  int due[$];
  int qq[$];
  int left = 0;
  int cur = 0;
  int seq [1<<QW];
  initial begin
    fill_vld = 1'b0; fill_data = '0;
    foreach (seq[i]) seq[i] = 0;
  end
  always @(posedge clk) tick <= tick + 1;
  always @(negedge clk) begin
    if (fetch_vld) begin due.push_back(tick + BLK - 1); qq.push_back(int'(fetch_qid)); end
    if (left == 0 && due.size() > 0 && due[0] <= tick) begin
      void'(due.pop_front()); cur = qq.pop_front(); left = BLK;
    end
    if (left > 0) begin
      fill_vld  <= 1'b1;
      fill_data <= {QW'(cur), (DW-QW)'(seq[cur])};
      seq[cur]  = seq[cur] + 1;
      left      = left - 1;
    end else fill_vld <= 1'b0;
  end
endmodule

module sim_hcache_prefetch;
  localparam int LA = 16, BLK = 4, QW = 2, DW = 8;
  // Stimulus table: {qid[5:4], triggers-fetch[3], idle gap[2:0]}
  localparam logic [5:0] VEC [12] = '{
    {2'd0,1'b1,3'd0}, {2'd0,1'b0,3'd0}, {2'd1,1'b1,3'd1}, {2'd0,1'b0,3'd0},
    {2'd0,1'b0,3'd2}, {2'd0,1'b1,3'd0}, {2'd2,1'b1,3'd0}, {2'd1,1'b0,3'd1},
    {2'd0,1'b0,3'd0}, {2'd3,1'b1,3'd0}, {2'd3,1'b0,3'd3}, {2'd1,1'b0,3'd0}};

  logic clk = 1'b0, rst_n;
  always #2 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic r0_vld, r1_vld, r2_vld;
  logic [QW-1:0] r0_q, r1_q, r2_q;
  logic f0, f1, f2, fl0, fl1, fl2, c0, c1, c2, d0, d1, d2;
  logic [QW-1:0] fq0, fq1, fq2, cq0, cq1, cq2, dq0, dq1, dq2;
  logic [DW-1:0] fd0, fd1, fd2, cd0, cd1, cd2;

  hcache_prefetch u0 (.clk(clk), .rst_n(rst_n), .req_vld(r0_vld), .req_qid(r0_q),
    .fetch_vld(f0), .fetch_qid(fq0), .fill_vld(fl0), .fill_data(fd0),
    .cell_vld(c0), .cell_qid(cq0), .cell_data(cd0), .drop_vld(d0), .drop_qid(dq0));
  hcache_prefetch #(.NCELL(4)) u1 (.clk(clk), .rst_n(rst_n), .req_vld(r1_vld), .req_qid(r1_q),
    .fetch_vld(f1), .fetch_qid(fq1), .fill_vld(fl1), .fill_data(fd1),
    .cell_vld(c1), .cell_qid(cq1), .cell_data(cd1), .drop_vld(d1), .drop_qid(dq1));
  hcache_prefetch #(.LA(4)) u2 (.clk(clk), .rst_n(rst_n), .req_vld(r2_vld), .req_qid(r2_q),
    .fetch_vld(f2), .fetch_qid(fq2), .fill_vld(fl2), .fill_data(fd2),
    .cell_vld(c2), .cell_qid(cq2), .cell_data(cd2), .drop_vld(d2), .drop_qid(dq2));
  sim_mem m0 (.clk(clk), .fetch_vld(f0), .fetch_qid(fq0), .fill_vld(fl0), .fill_data(fd0));
  sim_mem m1 (.clk(clk), .fetch_vld(f1), .fetch_qid(fq1), .fill_vld(fl1), .fill_data(fd1));
  sim_mem m2 (.clk(clk), .fetch_vld(f2), .fetch_qid(fq2), .fill_vld(fl2), .fill_data(fd2));

  int nchk = 0, nbad = 0, nf1 = 0;
  bit done = 0;
  int exp_f[$], got_f[$], et[$], eq[$];
  int exp_seq [4] = '{0, 0, 0, 0};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // u0 outcome monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (f0) got_f.push_back(int'(fq0));
      if (f1) nf1++;
      if (c0 || d0) begin
        if (et.size() == 0) chk(1'b0, "R1 unexpected outcome", int'(cq0), -1);
        else begin
          int t, q;
          t = et.pop_front(); q = eq.pop_front();
          chk(cyc == t + LA, "R1 outcome latency", cyc, t + LA);
          chk(c0 == 1'b1, "R7 unexpected drop", int'(d0), 0);
          chk(int'(cq0) == q, "R1 outcome qid", int'(cq0), q);
          chk(int'(cd0) == q * 64 + exp_seq[q], "R2 cell order", int'(cd0), q * 64 + exp_seq[q]);
          exp_seq[q]++;
        end
      end
    end
  end

  task automatic send0(input int q);
    r0_vld = 1'b1; r0_q = QW'(q);
    et.push_back(cyc + 1); eq.push_back(q);
    @(negedge clk);
    r0_vld = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  initial begin
    rst_n = 1'b0;
    r0_vld = 0; r1_vld = 0; r2_vld = 0; r0_q = '0; r1_q = '0; r2_q = '0;
    repeat (3) @(negedge clk);
    chk(!f0 && !c0 && !d0, "R9 reset outputs u0", int'({f0, c0, d0}), 0);
    chk(!f1 && !c1 && !d1 && !f2 && !c2 && !d2, "R9 reset outputs u1/u2",
        int'({f1, c1, d1, f2, c2, d2}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk (R1, R2, R3, R4)
    foreach (VEC[i]) begin
      if (VEC[i][3]) exp_f.push_back(int'(VEC[i][5:4]));
      send0(int'(VEC[i][5:4]));
      repeat (int'(VEC[i][2:0])) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(got_f.size() == exp_f.size(), "R3 fetch count", got_f.size(), exp_f.size());
    foreach (exp_f[i])
      if (i < got_f.size()) chk(got_f[i] == exp_f[i], "R4 fetch order", got_f[i], exp_f[i]);
    chk(et.size() == 0, "R1 outcomes outstanding", et.size(), 0);

    // Idle: no critical queue, no fetch (R8)
    begin
      int nf;
      nf = got_f.size();
      repeat (20) @(negedge clk);
      chk(got_f.size() == nf, "R8 idle fetch", got_f.size(), nf);
    end

    // Leftover cells of queue 2 serve later requests; 5th request fetches again (R2, R3)
    for (int k = 0; k < 4; k++) begin send0(2); @(negedge clk); end
    repeat (40) @(negedge clk);
    chk(got_f.size() == 6, "R3 fetch on 5th request", got_f.size(), 6);
    if (got_f.size() == 6) chk(got_f[5] == 2, "R3 fetch queue", got_f[5], 2);
    chk(exp_seq[2] == 5, "R2 leftover cells used", exp_seq[2], 5);

    // Short lookahead: first request outruns its fetch (R7)
    r2_vld = 1'b1; r2_q = 2'd1;
    @(negedge clk); r2_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk(!d2 && !c2, "R1 no early outcome", int'({d2, c2}), 0);
    @(negedge clk);
    chk(d2 && !c2, "R7 late drop", int'({d2, c2}), 2);
    chk(dq2 == 2'd1, "R7 drop qid", int'(dq2), 1);
    @(negedge clk);
    chk(!d2, "R7 drop one cycle", int'(d2), 0);
    repeat (20) @(negedge clk);
    r2_vld = 1'b1; r2_q = 2'd1;
    @(negedge clk); r2_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk(c2 && cd2 == 8'h40, "R2 late block kept", int'(cd2), 8'h40);

    // Store of one block: second fetch held for space (R6)
    r1_vld = 1'b1; r1_q = 2'd0;
    @(negedge clk); r1_q = 2'd1;
    @(negedge clk); r1_vld = 1'b0;
    repeat (LA - 1) @(negedge clk);
    chk(c1 && cq1 == 2'd0 && cd1 == 8'h00, "R6 first queue served", int'(cd1), 0);
    @(negedge clk);
    chk(d1 && dq1 == 2'd1, "R6 second queue dropped", int'({d1, dq1}), 5);
    repeat (20) @(negedge clk);
    chk(nf1 == 1, "R6 fetch withheld", nf1, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule